// File: doc/BRIEF.md
# Barrel Shifter with Carry-Through Forms

This block is a word-wide shift and rotate datapath with a one-bit carry flag held in a register. One operand word is shifted or rotated per accepted request. The amount comes from one of two places. It is either a full register value, where counts at or beyond the word width saturate, or a 5-bit immediate count. For four of the immediate operations, a count of zero does not mean "no shift". It selects a one-bit shift or rotate that passes a bit through the carry.

A request is a valid strobe plus the operation code, the operand, the amount word, the incoming carry and a carry write enable. The result word is registered and appears with `out_valid` one cycle after the request. The carry flag register is rewritten only when the write enable is high and the operation actually produces a carry. Instruction decode and register file access sit outside the block.

Top module: `shf_unit`

## Requirements
- R1: Operation code 3'd0 (register logical left) returns the operand shifted left by `amount`. When the full 32-bit `amount` is 32 or more, the result is zero. An amount of 0x100 gives zero, not the unshifted operand.
- R2: Operation code 3'd1 (register logical right) returns the operand shifted right with zero fill. When the full 32-bit `amount` is 32 or more, the result is zero.
- R3: Operation code 3'd2 (register arithmetic right) shifts right with sign fill. When `amount` exceeds 30, the result is all ones for a negative operand and all zeros otherwise.
- R4: Operation code 3'd3 (immediate rotate) with a nonzero count n = `amount[4:0]` returns the operand rotated left by n bits.
- R5: Operation code 3'd3 with a count of zero rotates right by one through the carry. The new bit 31 is `cin`, and the produced carry is operand bit 0.
- R6: Operation code 3'd4 (immediate arithmetic right) with a count of zero shifts right by one and keeps the sign bit. The produced carry is operand bit 0.
- R7: Operation code 3'd5 (immediate logical left) with a count of zero shifts left by one. The produced carry is operand bit 31.
- R8: Operation code 3'd6 (immediate logical right) with a count of zero shifts right by one with zero fill. The produced carry is operand bit 0.
- R9: Immediate operations with a nonzero count shift by `amount[4:0]` and ignore `amount[31:5]`. They produce no carry, so `carry_flag` keeps its value.
- R10: `carry_flag` changes only on a valid request that has `carry_we` high and uses a zero-count immediate operation (codes 3'd3 to 3'd6). Register-amount operations never change it.
- R11: After a synchronous reset, `result`, `carry_flag` and `out_valid` are zero. A request accepted on one rising edge shows its `result` and `out_valid` at that edge, so both are readable in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (see R1 to R9) |
| operand | input | 32 | Word to shift or rotate |
| amount | input | 32 | Register amount, or an immediate count in bits 4:0 |
| cin | input | 1 | Carry fed into the rotate-through-carry form |
| carry_we | input | 1 | Allows the carry flag register to be written |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Registered shift or rotate result |
| carry_flag | output | 1 | Registered carry flag |

## Verification
The carry flag is the only state that outlives a request, so that is where a fault in its write gating shows. A flag that moves on a register op or a nonzero immediate, or that ignores `carry_we`, shows up on `carry_flag` one cycle after the offending request. A saturation compare that looks only at the low five amount bits shows up as a wrapped, non-zero `result` in the cycle after an amount such as 0x100. Every request is checked against an independently computed result and flag in the cycle after it is accepted, so any fault is reported against the request that exposed it.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    SH_LSL_REG = 3'd0,
    SH_LSR_REG = 3'd1,
    SH_ASR_REG = 3'd2,
    SH_ROT_IMM = 3'd3,
    SH_ASR_IMM = 3'd4,
    SH_LSL_IMM = 3'd5,
    SH_LSR_IMM = 3'd6,
    SH_PASS    = 3'd7
  } shf_op_e;

  // Result source selected by the control stage
  typedef enum logic [2:0] {
    SRC_LEFT,
    SRC_RIGHT,
    SRC_ROT,
    SRC_ZERO,
    SRC_FILL,
    SRC_ONE,
    SRC_PASS
  } shf_src_e;

  function automatic logic is_imm_op(input shf_op_e o);
    return (o == SH_ROT_IMM) || (o == SH_ASR_IMM) ||
           (o == SH_LSL_IMM) || (o == SH_LSR_IMM);
  endfunction

endpackage

// File: rtl/shf_lbarrel.sv
module shf_lbarrel #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] sh,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [AW+1];

  assign stg[0] = din;

  // One conditional power-of-two stage per amount bit
  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = sh[s] ? {stg[s][W-1-D:0], {D{1'b0}}} : stg[s];
  end

  assign dout = stg[AW];

endmodule

// File: rtl/shf_rbarrel.sv
module shf_rbarrel #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] sh,
  input  logic          fill,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [AW+1];

  assign stg[0] = din;

  // Vacated high bits take the fill bit (zero or sign)
  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = sh[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
  end

  assign dout = stg[AW];

endmodule

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shf_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [2:0]    op,
  input  logic [W-1:0]  operand,
  input  logic [W-1:0]  amount,
  input  logic          cin,
  output logic [AW-1:0] lsh,
  output logic [AW-1:0] rsh,
  output logic          rfill,
  output shf_src_e      src,
  output logic [W-1:0]  one_res,
  output logic          cgen,
  output logic          cval
);

  localparam logic [W-1:0] LIM_LOG = W - 1;  // logical shifts saturate above this
  localparam logic [W-1:0] LIM_ARI = W - 2;  // arithmetic shift saturates above this

  shf_op_e         opc;
  logic [AW-1:0]   cnt;
  logic            cnt_zero;
  logic            big_log;
  logic            big_ari;

  assign opc      = shf_op_e'(op);
  assign cnt      = amount[AW-1:0];
  assign cnt_zero = (cnt == '0);
  // Full-width compares: upper amount bits take part
  assign big_log  = (amount > LIM_LOG);
  assign big_ari  = (amount > LIM_ARI);

  always_comb begin
    lsh     = cnt;
    rsh     = cnt;
    rfill   = 1'b0;
    src     = SRC_PASS;
    one_res = operand;
    cgen    = 1'b0;
    cval    = 1'b0;
    unique case (opc)
      SH_LSL_REG: src = big_log ? SRC_ZERO : SRC_LEFT;
      SH_LSR_REG: src = big_log ? SRC_ZERO : SRC_RIGHT;
      SH_ASR_REG: begin
        rfill = operand[W-1];
        src   = big_ari ? SRC_FILL : SRC_RIGHT;
      end
      SH_ROT_IMM: begin
        if (cnt_zero) begin
          src     = SRC_ONE;
          one_res = {cin, operand[W-1:1]};
          cgen    = 1'b1;
          cval    = operand[0];
        end else begin
          // W - n, modulo W, is the right-hand half of the rotate
          rsh = -cnt;
          src = SRC_ROT;
        end
      end
      SH_ASR_IMM: begin
        rfill = operand[W-1];
        if (cnt_zero) begin
          src     = SRC_ONE;
          one_res = {operand[W-1], operand[W-1:1]};
          cgen    = 1'b1;
          cval    = operand[0];
        end else begin
          src = SRC_RIGHT;
        end
      end
      SH_LSL_IMM: begin
        if (cnt_zero) begin
          src     = SRC_ONE;
          one_res = {operand[W-2:0], 1'b0};
          cgen    = 1'b1;
          cval    = operand[W-1];
        end else begin
          src = SRC_LEFT;
        end
      end
      SH_LSR_IMM: begin
        if (cnt_zero) begin
          src     = SRC_ONE;
          one_res = {1'b0, operand[W-1:1]};
          cgen    = 1'b1;
          cval    = operand[0];
        end else begin
          src = SRC_RIGHT;
        end
      end
      default: src = SRC_PASS;
    endcase
  end

endmodule

// File: rtl/shf_flag.sv
module shf_flag (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] amount,
  input  logic         cin,
  input  logic         carry_we,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         carry_flag
);

  localparam int AW = $clog2(W);

  logic [AW-1:0] lsh, rsh;
  logic          rfill;
  shf_src_e      src;
  logic [W-1:0]  one_res;
  logic          cgen, cval;
  logic [W-1:0]  lres, rres, res_d;

  shf_ctrl #(.W(W), .AW(AW)) u_ctrl (
    .op      (op),
    .operand (operand),
    .amount  (amount),
    .cin     (cin),
    .lsh     (lsh),
    .rsh     (rsh),
    .rfill   (rfill),
    .src     (src),
    .one_res (one_res),
    .cgen    (cgen),
    .cval    (cval)
  );

  shf_lbarrel #(.W(W), .AW(AW)) u_left (
    .din  (operand),
    .sh   (lsh),
    .dout (lres)
  );

  shf_rbarrel #(.W(W), .AW(AW)) u_right (
    .din  (operand),
    .sh   (rsh),
    .fill (rfill),
    .dout (rres)
  );

  always_comb begin
    unique case (src)
      SRC_LEFT:  res_d = lres;
      SRC_RIGHT: res_d = rres;
      SRC_ROT:   res_d = lres | rres;
      SRC_ZERO:  res_d = '0;
      SRC_FILL:  res_d = {W{operand[W-1]}};
      SRC_ONE:   res_d = one_res;
      default:   res_d = operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_d;
    end
  end

  shf_flag u_flag (
    .clk (clk),
    .rst (rst),
    .we  (in_valid & carry_we & cgen),
    .d   (cval),
    .q   (carry_flag)
  );

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk
  import shf_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [2:0]   op,
  input logic [W-1:0] operand,
  input logic [W-1:0] amount,
  input logic         cin,
  input logic         carry_we,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         carry_flag
);

  localparam int AW = $clog2(W);
  localparam logic [W-1:0] WIDTH_V = W;
  localparam logic [W-1:0] ARI_LIM = W - 2;

  logic imm_op, cnt_zero, carry_form;
  assign imm_op     = is_imm_op(shf_op_e'(op));
  assign cnt_zero   = (amount[AW-1:0] == '0);
  assign carry_form = in_valid && carry_we && imm_op && cnt_zero;

  p_lsl_sat_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == SH_LSL_REG && amount >= WIDTH_V |=> result == '0)
    else $error("p_lsl_sat_r1");

  p_lsr_sat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == SH_LSR_REG && amount >= WIDTH_V |=> result == '0)
    else $error("p_lsr_sat_r2");

  p_asr_sat_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == SH_ASR_REG && amount > ARI_LIM
    |=> result == {W{$past(operand[W-1])}})
    else $error("p_asr_sat_r3");

  p_rot_carry_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && carry_we && op == SH_ROT_IMM && cnt_zero
    |=> result == {$past(cin), $past(operand[W-1:1])} && carry_flag == $past(operand[0]))
    else $error("p_rot_carry_r5");

  p_imm_keep_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && imm_op && !cnt_zero |=> $stable(carry_flag))
    else $error("p_imm_keep_r9");

  p_flag_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !carry_form |=> $stable(carry_flag))
    else $error("p_flag_gate_r10");

  p_valid_on_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid)
    else $error("p_valid_on_r11");

  p_valid_off_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid)
    else $error("p_valid_off_r11");

endmodule

bind shf_unit shf_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .op         (op),
  .operand    (operand),
  .amount     (amount),
  .cin        (cin),
  .carry_we   (carry_we),
  .out_valid  (out_valid),
  .result     (result),
  .carry_flag (carry_flag)
);

// File: tb/shf_unit_test.sv
`timescale 1ns/1ps
module shf_unit_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   op = '0;
  logic [W-1:0] operand = '0;
  logic [W-1:0] amount = '0;
  logic         cin = 1'b0;
  logic         carry_we = 1'b0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         carry_flag;

  int n_cmp = 0;
  int n_bad = 0;
  logic model_c = 1'b0;

  typedef struct {
    logic [W-1:0] res;
    logic         c;
    string        tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  shf_unit #(.W(W)) uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op         (op),
    .operand    (operand),
    .amount     (amount),
    .cin        (cin),
    .carry_we   (carry_we),
    .out_valid  (out_valid),
    .result     (result),
    .carry_flag (carry_flag)
  );

  // Expected behaviour, written from the requirement list
  function automatic void model(input logic [2:0] o, input logic [W-1:0] x, a,
                                input logic c, output logic [W-1:0] r,
                                output logic cg, output logic cv);
    logic [4:0]    n;
    logic [63:0]   dbl;
    n   = a[4:0];
    dbl = {x, x};
    cg  = 1'b0;
    cv  = 1'b0;
    case (o)
      3'd0: r = x << a;
      3'd1: r = x >> a;
      3'd2: r = W'($signed(x) >>> a);
      3'd3: if (n == 0) begin r = {c, x[31:1]}; cg = 1; cv = x[0]; end
            else begin dbl = dbl << n; r = dbl[63:32]; end
      3'd4: if (n == 0) begin r = {x[31], x[31:1]}; cg = 1; cv = x[0]; end
            else r = W'($signed(x) >>> n);
      3'd5: if (n == 0) begin r = {x[30:0], 1'b0}; cg = 1; cv = x[31]; end
            else r = x << n;
      3'd6: if (n == 0) begin r = {1'b0, x[31:1]}; cg = 1; cv = x[0]; end
            else r = x >> n;
      default: r = x;
    endcase
  endfunction

  task automatic drive(input logic [2:0] o, input logic [W-1:0] x, a,
                       input logic c, we, input string tag);
    exp_t e;
    logic cg, cv;
    @(negedge clk);
    in_valid = 1'b1;
    op = o; operand = x; amount = a; cin = c; carry_we = we;
    model(o, x, a, c, e.res, cg, cv);
    if (we && cg) model_c = cv;
    e.c   = model_c;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare registered outputs in the cycle after acceptance
  always @(negedge clk) begin
    #1;
    if (!rst && out_valid) begin
      n_cmp++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R11 unexpected out_valid: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (result !== e.res || carry_flag !== e.c) begin
          n_bad++;
          $display("FAIL %s: actual res=%h c=%b expected res=%h c=%b",
                   e.tag, result, carry_flag, e.res, e.c);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    n_cmp++;
    if (result !== '0 || carry_flag !== 1'b0 || out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset: actual res=%h c=%b v=%b expected 0 0 0",
               result, carry_flag, out_valid);
    end

    // R1 register logical left
    drive(3'd0, 32'h8000_0001, 32'd4,     0, 1, "R1 lsl 4");
    drive(3'd0, 32'h8000_0001, 32'd31,    0, 1, "R1 lsl 31");
    drive(3'd0, 32'hFFFF_FFFF, 32'd32,    0, 1, "R1 lsl 32");
    drive(3'd0, 32'h1234_5678, 32'h100,   0, 1, "R1 lsl 0x100");
    drive(3'd0, 32'h1234_5678, 32'd0,     0, 1, "R1 lsl 0");
    // R2 register logical right
    drive(3'd1, 32'hF000_000F, 32'd8,     0, 1, "R2 lsr 8");
    drive(3'd1, 32'hF000_000F, 32'h20,    0, 1, "R2 lsr 32");
    drive(3'd1, 32'hF000_000F, 32'hFFFF_FFFF, 0, 1, "R2 lsr max");
    // R3 register arithmetic right
    drive(3'd2, 32'h8000_0000, 32'd4,     0, 1, "R3 asr 4");
    drive(3'd2, 32'h8000_0000, 32'd31,    0, 1, "R3 asr 31");
    drive(3'd2, 32'h8765_4321, 32'h40,    0, 1, "R3 asr neg 0x40");
    drive(3'd2, 32'h7FFF_FFFF, 32'd99,    0, 1, "R3 asr pos 99");
    // R4 immediate rotate
    drive(3'd3, 32'h1234_5678, 32'd8,     0, 1, "R4 rot 8");
    drive(3'd3, 32'h8000_0001, 32'd1,     0, 1, "R4 rot 1");
    drive(3'd3, 32'h1234_5678, 32'd31,    0, 1, "R4 rot 31");
    // R5 rotate through carry
    drive(3'd3, 32'h0000_0002, 32'd0,     1, 1, "R5 rrc cin1");
    drive(3'd3, 32'h0000_0001, 32'd0,     0, 1, "R5 rrc cin0");
    // R6, R7, R8 one-bit carry forms
    drive(3'd4, 32'h8000_0002, 32'd0,     0, 1, "R6 asr1 c0");
    drive(3'd4, 32'h8000_0003, 32'd0,     0, 1, "R6 asr1 c1");
    drive(3'd5, 32'h0000_0001, 32'd0,     0, 1, "R7 lsl1 c0");
    drive(3'd5, 32'h8000_0001, 32'd0,     0, 1, "R7 lsl1 c1");
    drive(3'd6, 32'h8000_0002, 32'd0,     0, 1, "R8 lsr1 c0");
    drive(3'd6, 32'h0000_0003, 32'd0,     0, 1, "R8 lsr1 c1");
    // R9 nonzero immediates keep carry, ignore upper amount bits
    drive(3'd5, 32'h0000_00F1, 32'h0000_0024, 0, 1, "R9 lsli upper ignored");
    drive(3'd6, 32'hF000_0001, 32'd4,     0, 1, "R9 lsri keep c");
    drive(3'd4, 32'h8000_0001, 32'hFFFF_FFE3, 0, 1, "R9 asri 3");
    drive(3'd5, 32'h8000_0001, 32'h0000_0020, 0, 1, "R9 count field zero");
    // R10 flag gating
    drive(3'd6, 32'h0000_0000, 32'd0,     0, 0, "R10 we low");
    drive(3'd0, 32'h0000_0000, 32'd1,     0, 1, "R10 reg op");
    drive(3'd7, 32'hCAFE_F00D, 32'd0,     0, 1, "R10 pass op");
    drive(3'd6, 32'h0000_0000, 32'd0,     0, 1, "R10 we high");
    idle();
    repeat (2) @(negedge clk);
    // R11 valid drops after idle
    n_cmp++;
    if (out_valid !== 1'b0 || sb.size() != 0) begin
      n_bad++;
      $display("FAIL R11 idle: actual v=%b pending=%0d expected 0 0",
               out_valid, sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule